// File: doc/BRIEF.md
# EEPROM Write-Combining Controller

This controller sits in front of a slow non-volatile byte memory whose every physical program cycle takes tens of milliseconds. Byte writes arrive on a valid/ready request port. The controller first compares each write with the byte the memory would return. That is the byte held in its combine buffer if that byte is pending, and otherwise the byte in the array. A write that changes nothing is discarded. Writes that do change data are collected per aligned group of eight bytes. The group is programmed in one cycle once the writer moves to another group, or once the writer stays silent for a programmable idle time.

The memory side is a group-wide read port and a one-cycle program strobe. The strobe carries a group index, an eight-bit byte-enable mask and 64 bits of data. A program strobe starts a busy period of a parameterised number of clocks, which stands for the 20 ms erase/write time. All requests stall during that period. A refresh command reprograms a whole group on purpose, even if nothing changed, so that retention can be renewed. Byte reads on the same port return the data a later program would leave in the array.

Top module: `nvm_wcomb`

## Requirements
- R1: After reset, `busy`, `prog_stb` and `rd_valid` are low and `req_ready` is high.
- R2: A write whose data equals the current byte (the pending buffered byte, or else the stored byte) is discarded. It never causes a program strobe and it does not restart the idle timer.
- R3: Writes to one aligned group (address bits above bit 2) are merged into a single program. Byte lane i of the group, which is address bits [2:0], maps to mask bit i and data bits [8i+7:8i]. Writing every byte of N consecutive groups in order gives exactly N programs, each with mask 8'hFF, and leaves the array holding the written data.
- R4: A changing write to a group other than the pending one programs the pending group in the cycle after that write is accepted. The new byte then starts a new pending group.
- R5: A pending group with no accepted request for IDLE_CYC cycles is programmed. The strobe appears IDLE_CYC+1 clock edges after the edge that accepted the last changing write.
- R6: From the cycle of a program strobe, `busy` stays high for exactly BUSY_CYC cycles. `req_ready` is low whenever `busy` is high, and no program starts while busy.
- R7: A read (`req_wr`=0, `req_rfsh`=0) is answered on `rd_valid`/`rd_data` in the cycle after acceptance. The answer is the buffered byte if that byte is pending, else the stored byte.
- R8: A refresh (`req_rfsh`=1, which takes priority over `req_wr`) of the pending group or with nothing pending programs that group in the next cycle. The mask is 8'hFF and the data is the stored bytes overlaid with any pending bytes of that group, even when no byte differs.
- R9: A refresh of a group other than the pending one programs the pending group first. The refresh program follows in the first cycle after `busy` falls, and `req_ready` stays low until it has started.
- R10: A program strobe lasts one cycle. Its mask has exactly the bits of the bytes changed by merged writes, and a later write to a buffered byte replaces that byte's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_wr | input | 1 | 1 = byte write, 0 = byte read |
| req_rfsh | input | 1 | Refresh the group addressed by req_addr |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | 8 | Read answer byte |
| mem_rgrp | output | ADDR_W-3 | Group index for the array read port |
| mem_rdata | input | 64 | Stored group contents, lane i in bits [8i+7:8i] |
| prog_stb | output | 1 | One-cycle program command |
| prog_grp | output | ADDR_W-3 | Group to program |
| prog_mask | output | 8 | Byte lanes to program |
| prog_data | output | 64 | Program data by lane |
| busy | output | 1 | Erase/write cycle in progress |

## Verification
The bench sweeps a full 64-byte array with writes that all change data. A controller that flushes on every write, or that loses the last group, shows up as the wrong program count or as array contents that differ from the expected values. Rewrites of unchanged data, whether they match the array or only the buffer, would show up as extra strobes if the comparison looked at the wrong byte. The strobe is sampled on the exact edge for the idle flush, the group-change flush and the deferred refresh, so an off-by-one timer or a refresh that skips the pending group is caught. Reads of pending bytes return the old array value if the buffer bypass is missing. A refresh of a matching group produces no strobe at all if it is wrongly treated as a write.

// File: rtl/nvm_wc_pkg.sv
package nvm_wc_pkg;

  localparam int LANES = 8;

  typedef enum logic [1:0] {
    BOP_HOLD   = 2'd0,
    BOP_CLEAR  = 2'd1,
    BOP_UPDATE = 2'd2,
    BOP_LOAD   = 2'd3
  } buf_op_e;

  function automatic logic [7:0] lane_get(logic [63:0] w, logic [2:0] i);
    return w[{i, 3'b000} +: 8];
  endfunction

  function automatic logic [63:0] lane_put(logic [63:0] w, logic [2:0] i, logic [7:0] b);
    logic [63:0] r;
    r = w;
    r[{i, 3'b000} +: 8] = b;
    return r;
  endfunction

  function automatic logic [7:0] lane_bit(logic [2:0] i);
    return 8'(1) << i;
  endfunction

  function automatic logic [63:0] lane_merge(logic [63:0] base, logic [63:0] over, logic [7:0] m);
    logic [63:0] r;
    r = base;
    for (int l = 0; l < LANES; l++) begin
      if (m[l]) r[l*8 +: 8] = over[l*8 +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/nvm_wc_down.sv
module nvm_wc_down #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nvm_wc_buf.sv
module nvm_wc_buf
  import nvm_wc_pkg::*;
#(
  parameter int GW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  buf_op_e       op,
  input  logic [GW-1:0] ld_grp,
  input  logic [7:0]    ld_mask,
  input  logic [63:0]   ld_data,
  input  logic          ld_force,
  input  logic [2:0]    up_lane,
  input  logic [7:0]    up_byte,
  output logic          pend,
  output logic          force_q,
  output logic [GW-1:0] grp,
  output logic [7:0]    mask,
  output logic [63:0]   data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      force_q <= 1'b0;
      grp     <= '0;
      mask    <= '0;
      data    <= '0;
    end else begin
      case (op)
        BOP_CLEAR: begin
          pend    <= 1'b0;
          force_q <= 1'b0;
          mask    <= '0;
        end
        BOP_UPDATE: begin
          mask <= mask | lane_bit(up_lane);
          data <= lane_put(data, up_lane, up_byte);
        end
        BOP_LOAD: begin
          pend    <= 1'b1;
          force_q <= ld_force;
          grp     <= ld_grp;
          mask    <= ld_mask;
          data    <= ld_data;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nvm_wcomb.sv
module nvm_wcomb
  import nvm_wc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BUSY_CYC = 5_000_000,
  parameter int IDLE_CYC = 250_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic              req_rfsh,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-4:0] mem_rgrp,
  input  logic [63:0]       mem_rdata,
  output logic              prog_stb,
  output logic [ADDR_W-4:0] prog_grp,
  output logic [7:0]        prog_mask,
  output logic [63:0]       prog_data,
  output logic              busy
);
  localparam int GW  = ADDR_W - 3;
  localparam int BCW = $clog2(BUSY_CYC + 1);
  localparam int ICW = $clog2(IDLE_CYC + 1);

  logic          b_pend, b_force;
  logic [GW-1:0] b_grp;
  logic [7:0]    b_mask;
  logic [63:0]   b_data;
  logic          busy_zero, idle_zero;

  logic [GW-1:0] grp_in;
  logic [2:0]    lane_in;
  logic          hit_grp, buf_has;
  logic [7:0]    cur_byte;
  logic          acc, is_wr, is_rd, is_rf;
  logic          drop_evt, wr_evt, flush_evt;

  buf_op_e       op;
  logic          prog_fire;
  logic [GW-1:0] f_grp;
  logic [7:0]    f_mask, ld_mask;
  logic [63:0]   f_data, ld_data;
  logic          ld_force;

  assign grp_in    = req_addr[ADDR_W-1:3];
  assign lane_in   = req_addr[2:0];
  assign mem_rgrp  = grp_in;
  assign hit_grp   = b_pend && (b_grp == grp_in);
  assign buf_has   = hit_grp && b_mask[lane_in];
  assign cur_byte  = buf_has ? lane_get(b_data, lane_in) : lane_get(mem_rdata, lane_in);

  assign busy      = !busy_zero;
  assign req_ready = !busy && !b_force;
  assign acc       = req_valid && req_ready;
  assign is_rf     = acc && req_rfsh;
  assign is_wr     = acc && !req_rfsh && req_wr;
  assign is_rd     = acc && !req_rfsh && !req_wr;
  assign drop_evt  = is_wr && (req_wdata == cur_byte);
  assign wr_evt    = is_wr && !drop_evt;
  assign flush_evt = b_pend && !busy && !acc && (idle_zero || b_force);

  always_comb begin
    op        = BOP_HOLD;
    prog_fire = 1'b0;
    f_grp     = b_grp;
    f_mask    = b_mask;
    f_data    = b_data;
    ld_mask   = '0;
    ld_data   = '0;
    ld_force  = 1'b0;
    if (flush_evt) begin
      prog_fire = 1'b1;
      op        = BOP_CLEAR;
    end else if (wr_evt) begin
      if (hit_grp) begin
        op = BOP_UPDATE;
      end else begin
        op        = BOP_LOAD;
        ld_mask   = lane_bit(lane_in);
        ld_data   = lane_put('0, lane_in, req_wdata);
        prog_fire = b_pend;
      end
    end else if (is_rf) begin
      prog_fire = 1'b1;
      if (b_pend && !hit_grp) begin
        op       = BOP_LOAD;
        ld_mask  = '1;
        ld_data  = mem_rdata;
        ld_force = 1'b1;
      end else begin
        op     = BOP_CLEAR;
        f_grp  = grp_in;
        f_mask = '1;
        f_data = lane_merge(mem_rdata, b_data, hit_grp ? b_mask : 8'h00);
      end
    end
  end

  nvm_wc_buf #(.GW(GW)) u_buf (
    .clk(clk), .rst_n(rst_n), .op(op),
    .ld_grp(grp_in), .ld_mask(ld_mask), .ld_data(ld_data), .ld_force(ld_force),
    .up_lane(lane_in), .up_byte(req_wdata),
    .pend(b_pend), .force_q(b_force), .grp(b_grp), .mask(b_mask), .data(b_data)
  );

  nvm_wc_down #(.CW(BCW)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(prog_fire),
    .load_val(BCW'(BUSY_CYC)), .zero(busy_zero)
  );

  nvm_wc_down #(.CW(ICW)) u_idle (
    .clk(clk), .rst_n(rst_n), .load(op == BOP_UPDATE || op == BOP_LOAD),
    .load_val(ICW'(IDLE_CYC)), .zero(idle_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_stb  <= 1'b0;
      prog_grp  <= '0;
      prog_mask <= '0;
      prog_data <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      prog_stb <= prog_fire;
      if (prog_fire) begin
        prog_grp  <= f_grp;
        prog_mask <= f_mask;
        prog_data <= f_data;
      end
      rd_valid <= is_rd;
      if (is_rd) rd_data <= cur_byte;
    end
  end
endmodule

// File: rtl/nvm_wcomb_chk.sv
module nvm_wcomb_chk #(
  parameter int BUSY_CYC = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_wr,
  input logic       req_rfsh,
  input logic       busy,
  input logic       prog_stb,
  input logic [7:0] prog_mask,
  input logic       rd_valid,
  input logic       drop_evt,
  input logic       prog_fire
);
  logic [31:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  // R6
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R6
  prog_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |-> busy);
  // R6
  fire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire |-> !busy);
  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= 32'(BUSY_CYC));
  // R10
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |=> !prog_stb);
  // R10
  mask_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |-> (prog_mask != 8'h00));
  // R2
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !prog_stb);
  // R7
  rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && req_ready && !req_wr && !req_rfsh));
endmodule

bind nvm_wcomb nvm_wcomb_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_wr(req_wr), .req_rfsh(req_rfsh), .busy(busy), .prog_stb(prog_stb),
  .prog_mask(prog_mask), .rd_valid(rd_valid), .drop_evt(drop_evt),
  .prog_fire(prog_fire)
);

// File: tb/nvm_wcomb_bench.sv
module nvm_wcomb_bench;
  localparam int AW   = 6;
  localparam int GW   = AW - 3;
  localparam int NB   = 1 << AW;
  localparam int BUSY = 6;
  localparam int IDLE = 10;
  localparam int SETTLE = IDLE + BUSY + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_wr = 1'b0, req_rfsh = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          req_ready, rd_valid, prog_stb, busy;
  logic [7:0]    rd_data, prog_mask;
  logic [GW-1:0] mem_rgrp, prog_grp;
  logic [63:0]   mem_rdata, prog_data;

  logic [NB*8-1:0] mem_flat = '0;
  logic [NB*8-1:0] exp_flat = '0;
  int n_prog = 0, n_part = 0, checks = 0, errors = 0;
  logic [GW-1:0] last_grp;
  logic [7:0]    last_mask;
  logic [63:0]   last_data;

  always #2 clk = ~clk;

  assign mem_rdata = mem_flat[mem_rgrp*64 +: 64];

  nvm_wcomb #(.ADDR_W(AW), .BUSY_CYC(BUSY), .IDLE_CYC(IDLE)) u_nvm_wcomb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_rfsh(req_rfsh), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_rgrp(mem_rgrp), .mem_rdata(mem_rdata),
    .prog_stb(prog_stb), .prog_grp(prog_grp), .prog_mask(prog_mask),
    .prog_data(prog_data), .busy(busy)
  );

  // behavioural array: applies each program strobe
  always @(negedge clk) begin
    if (rst_n && prog_stb) begin
      n_prog++;
      if (prog_mask != 8'hFF) n_part++;
      last_grp  = prog_grp;
      last_mask = prog_mask;
      last_data = prog_data;
      for (int l = 0; l < 8; l++)
        if (prog_mask[l]) mem_flat[(int'(prog_grp)*8 + l)*8 +: 8] = prog_data[l*8 +: 8];
    end
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_req(bit wr, bit rf, int a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_rfsh = rf;
    req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0; req_wr = 1'b0; req_rfsh = 1'b0;
  endtask

  task automatic set_exp(int a, logic [7:0] d);
    exp_flat[a*8 +: 8] = d;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    step(4);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    // R1
    check("R1 busy", busy, 0);
    check("R1 ready", req_ready, 1);
    check("R1 prog_stb", prog_stb, 0);
    check("R1 rd_valid", rd_valid, 0);

    // R3 sweep: every byte changes, one program per group
    for (int a = 0; a < NB; a++) begin
      do_req(1, 0, a, pat(a));
      set_exp(a, pat(a));
    end
    step(SETTLE);
    check("R3 program count", n_prog, NB / 8);
    check("R3 partial masks", n_part, 0);
    check("R3 array contents", mem_flat == exp_flat, 1);

    // R2 rewrite with unchanged data
    n0 = n_prog;
    do_req(1, 0, 5, pat(5));
    step(SETTLE);
    check("R2 unchanged write dropped", n_prog - n0, 0);

    // R5 idle flush timing
    n0 = n_prog;
    do_req(1, 0, 9, 8'h5A); set_exp(9, 8'h5A);
    step(IDLE);
    check("R5 no strobe before idle expiry", prog_stb, 0);
    step(1);
    check("R5 strobe at idle expiry", prog_stb, 1);
    check("R5 group", prog_grp, 1);
    check("R10 single lane mask", prog_mask, 8'h02);
    check("R5 lane data", prog_data[15:8], 8'h5A);
    step(BUSY + 2);

    // R4 group change flush, R6 busy window
    n0 = n_prog;
    do_req(1, 0, 16, 8'hA1); set_exp(16, 8'hA1);
    do_req(1, 0, 24, 8'hB2); set_exp(24, 8'hB2);
    check("R4 strobe on group change", prog_stb, 1);
    check("R4 old group", prog_grp, 2);
    check("R4 old mask", prog_mask, 8'h01);
    check("R6 busy after strobe", busy, 1);
    check("R6 ready low while busy", req_ready, 0);
    step(BUSY - 1);
    check("R6 busy at last cycle", busy, 1);
    step(1);
    check("R6 busy ends", busy, 0);
    step(SETTLE);
    check("R4 two programs", n_prog - n0, 2);
    check("R4 array contents", mem_flat == exp_flat, 1);

    // R7 reads with and without buffered byte
    do_req(1, 0, 33, 8'hC3); set_exp(33, 8'hC3);
    do_req(0, 0, 33, 8'h00);
    check("R7 rd_valid", rd_valid, 1);
    check("R7 buffered byte", rd_data, 8'hC3);
    do_req(0, 0, 34, 8'h00);
    check("R7 stored byte", rd_data, pat(34));
    step(SETTLE);

    // R8 refresh with no change
    n0 = n_prog;
    do_req(0, 1, 40, 8'h00);
    check("R8 refresh strobe", prog_stb, 1);
    check("R8 refresh mask", prog_mask, 8'hFF);
    check("R8 refresh data", prog_data, exp_flat[5*64 +: 64]);
    step(BUSY + 2);
    check("R8 one program", n_prog - n0, 1);

    // R10 overwrite in buffer, R2 drop against stored byte
    n0 = n_prog;
    do_req(1, 0, 40, 8'h11);
    do_req(1, 0, 40, 8'h22); set_exp(40, 8'h22);
    do_req(1, 0, 42, pat(42));
    step(SETTLE);
    check("R10 one merged program", n_prog - n0, 1);
    check("R10 mask only changed lane", last_mask, 8'h01);
    check("R10 latest data kept", last_data[7:0], 8'h22);

    // R9 refresh of another group while one is pending
    n0 = n_prog;
    do_req(1, 0, 48, 8'h66); set_exp(48, 8'h66);
    do_req(0, 1, 0, 8'h00);
    check("R9 pending flushed first", prog_grp, 6);
    check("R9 pending mask", prog_mask, 8'h01);
    step(BUSY);
    check("R9 ready held low", req_ready, 0);
    check("R9 no strobe yet", prog_stb, 0);
    step(1);
    check("R9 refresh strobe", prog_stb, 1);
    check("R9 refresh group", prog_grp, 0);
    check("R9 refresh mask", prog_mask, 8'hFF);
    check("R9 refresh data", prog_data, exp_flat[0 +: 64]);
    step(BUSY + 2);
    check("R9 two programs", n_prog - n0, 2);

    // R8 refresh merging pending bytes of same group
    n0 = n_prog;
    do_req(1, 0, 58, 8'h77); set_exp(58, 8'h77);
    do_req(0, 1, 56, 8'h00);
    check("R8 merged refresh strobe", prog_stb, 1);
    check("R8 merged refresh data", prog_data, exp_flat[7*64 +: 64]);
    step(SETTLE);
    check("R8 merged single program", n_prog - n0, 1);
    check("R3 final array", mem_flat == exp_flat, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule